// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working-register store of a small 8-bit RISC core: thirty-two byte-wide registers. Two read ports feed the ALU operands combinationally. One write port stores the ALU result at the next rising clock edge. Together they let an operand fetch, execute and write-back sequence finish inside a single clock.

The top six registers also serve as three 16-bit indirect pointers. A dedicated pointer port can inspect, load, post-increment or pre-decrement any one of them as a single 16-bit quantity. The same port also returns the effective address for the access. The third pointer (Z) is always visible on its own output so that program-memory constant lookups can use it.

The whole array also answers at the bottom of the data space. A load/store style port with a 16-bit address reads and writes the registers at addresses 0x0000 to 0x001F, and reports whether an address falls in that window. When several write sources touch the same register in one cycle, a fixed priority picks the winner.

Top module: `gpr_file`

## Requirements
- R1: After reset every one of the 32 registers reads as zero on both read ports.
- R2: Read ports A and B return, combinationally and independently, the stored byte of the register selected by their own 5-bit index.
- R3: An ALU write (alu_we=1) stores alu_wdata into register alu_waddr at the next rising edge. A read in the same cycle returns the old value, with no bypass.
- R4: A memory address from 0x0000 to 0x001F drives mem_hit high. mem_rdata then gives the register at the low 5 address bits, and mem_we=1 writes mem_wdata into that register at the next edge.
- R5: A memory address of 0x0020 or above drives mem_hit low and mem_rdata to zero. A write to such an address changes no register, including the one the low 5 bits would name.
- R6: Pointer select codes are X=0, Y=1, Z=2 and none=3. X is {r27,r26}, Y is {r29,r28} and Z is {r31,r30}, high byte at the odd index. z_ptr always shows Z.
- R7: Pointer op code 1 (load) writes the 16-bit ptr_wdata into both bytes of the selected pointer at the next edge.
- R8: Pointer op code 2 (post-increment) presents the current pointer value on ptr_addr and stores value+1, with carry between the bytes in the same cycle, wrapping 0xFFFF to 0x0000.
- R9: Pointer op code 3 (pre-decrement) presents value-1 on ptr_addr and stores that value, wrapping 0x0000 to 0xFFFF.
- R10: Pointer op code 0 (hold) presents the current pointer value on ptr_addr and changes nothing. Select code 3 (none) drives ptr_addr to zero and changes no register for any op.
- R11: When writes collide on one register in one cycle, the ALU write beats the pointer update, which beats the memory write. Writes to different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_addr | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_addr | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| alu_we | input | 1 | ALU result write enable |
| alu_waddr | input | 5 | ALU result register index |
| alu_wdata | input | 8 | ALU result byte |
| mem_addr | input | 16 | Data-space address |
| mem_we | input | 1 | Data-space write enable |
| mem_wdata | input | 8 | Data-space write byte |
| mem_rdata | output | 8 | Data-space read byte, zero outside the window |
| mem_hit | output | 1 | Address lies in the register window |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_op | input | 2 | Pointer op: 0 hold, 1 load, 2 post-increment, 3 pre-decrement |
| ptr_wdata | input | 16 | Pointer load value |
| ptr_addr | output | 16 | Effective address of the pointer access |
| z_ptr | output | 16 | Current Z pointer value |

## Verification
On every cycle the assertions check these behaviours:
- a committed ALU write shows up on read port A the next cycle;
- an uncontested memory write reads back through the memory port;
- the out-of-window address response stays correct;
- the effective address follows the pointer for hold and pre-decrement;
- a post-increment of Z advances z_ptr by exactly one.

Only the bench scenarios can show the rest:
- the full reset image;
- the same-cycle old-value read;
- the byte placement of each pointer pair;
- the carry and both wrap-arounds seen through the read ports;
- the three-way write priority;
- that writes outside the window leave an aliased register untouched.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    POP_HOLD    = 2'd0,
    POP_LOAD    = 2'd1,
    POP_POSTINC = 2'd2,
    POP_PREDEC  = 2'd3
  } pop_e;

endpackage

// File: rtl/gpr_rst_sync.sv
// Asynchronous assertion, synchronous two-stage release of the reset.
module gpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/gpr_ptr_unit.sv
// Computes the next pointer value and the effective address of one access.
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic [1:0]       op,
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] ldata,
  output logic [PTR_W-1:0] nxt,
  output logic [PTR_W-1:0] eff_addr,
  output logic             upd
);
  always_comb begin
    nxt      = cur;
    eff_addr = cur;
    upd      = 1'b0;
    case (pop_e'(op))
      POP_LOAD: begin
        nxt = ldata;
        upd = 1'b1;
      end
      POP_POSTINC: begin
        nxt = cur + PTR_W'(1);
        upd = 1'b1;
      end
      POP_PREDEC: begin
        nxt      = cur - PTR_W'(1);
        eff_addr = cur - PTR_W'(1);
        upd      = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpr_wsel.sv
// Per-register next-state select: ALU over pointer over memory.
module gpr_wsel #(
  parameter int DATA_W   = 8,
  parameter int AW       = 5,
  parameter int IDX      = 0,
  parameter int PTR_BASE = 26
) (
  input  logic                  alu_we,
  input  logic [AW-1:0]         alu_waddr,
  input  logic [DATA_W-1:0]     alu_wdata,
  input  logic                  ptr_upd,
  input  logic [1:0]            ptr_sel,
  input  logic [2*DATA_W-1:0]   ptr_nxt,
  input  logic                  mem_we,
  input  logic [AW-1:0]         mem_waddr,
  input  logic [DATA_W-1:0]     mem_wdata,
  output logic                  en,
  output logic [DATA_W-1:0]     d
);
  localparam bit            IS_PTR = (IDX >= PTR_BASE);
  localparam int            REL    = IS_PTR ? (IDX - PTR_BASE) : 0;
  localparam logic [1:0]    SLOT   = 2'(REL / 2);
  localparam bit            HIGH   = ((REL % 2) == 1);
  localparam logic [AW-1:0] MY     = AW'(IDX);

  logic              alu_hit;
  logic              ptr_hit;
  logic              mem_hit;
  logic [DATA_W-1:0] ptr_byte;

  always_comb begin
    alu_hit  = alu_we && (alu_waddr == MY);
    ptr_hit  = IS_PTR && ptr_upd && (ptr_sel == SLOT);
    mem_hit  = mem_we && (mem_waddr == MY);
    ptr_byte = HIGH ? ptr_nxt[2*DATA_W-1:DATA_W] : ptr_nxt[DATA_W-1:0];
    en       = alu_hit || ptr_hit || mem_hit;
    if (alu_hit)      d = alu_wdata;
    else if (ptr_hit) d = ptr_byte;
    else              d = mem_wdata;
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREGS  = 32,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREGS)-1:0] rd_a_addr,
  output logic [DATA_W-1:0]        rd_a_data,
  input  logic [$clog2(NREGS)-1:0] rd_b_addr,
  output logic [DATA_W-1:0]        rd_b_data,
  input  logic                     alu_we,
  input  logic [$clog2(NREGS)-1:0] alu_waddr,
  input  logic [DATA_W-1:0]        alu_wdata,
  input  logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_we,
  input  logic [DATA_W-1:0]        mem_wdata,
  output logic [DATA_W-1:0]        mem_rdata,
  output logic                     mem_hit,
  input  logic [1:0]               ptr_sel,
  input  logic [1:0]               ptr_op,
  input  logic [2*DATA_W-1:0]      ptr_wdata,
  output logic [2*DATA_W-1:0]      ptr_addr,
  output logic [2*DATA_W-1:0]      z_ptr
);
  localparam int AW       = $clog2(NREGS);
  localparam int PTR_W    = 2 * DATA_W;
  localparam int NPTR     = 3;
  localparam int PTR_BASE = NREGS - 2 * NPTR;

  logic              rst_q_n;
  logic [DATA_W-1:0] rf_q [NREGS];
  logic [PTR_W-1:0]  ptr_vals [4];
  logic [PTR_W-1:0]  ptr_cur;
  logic [PTR_W-1:0]  ptr_nxt;
  logic [PTR_W-1:0]  ptr_eff;
  logic              ptr_upd_raw;
  logic              sel_valid;
  logic              ptr_upd;
  logic              mem_we_hit;

  gpr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Pointer pairs: low byte at the even index.
  for (genvar p = 0; p < NPTR; p++) begin : g_pair
    assign ptr_vals[p] = {rf_q[PTR_BASE + 2*p + 1], rf_q[PTR_BASE + 2*p]};
  end
  assign ptr_vals[3] = '0;

  assign sel_valid = (ptr_sel != PSEL_NONE);
  assign ptr_cur   = ptr_vals[ptr_sel];

  gpr_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .op       (ptr_op),
    .cur      (ptr_cur),
    .ldata    (ptr_wdata),
    .nxt      (ptr_nxt),
    .eff_addr (ptr_eff),
    .upd      (ptr_upd_raw)
  );

  assign ptr_upd  = sel_valid && ptr_upd_raw;
  assign ptr_addr = sel_valid ? ptr_eff : '0;
  assign z_ptr    = ptr_vals[PSEL_Z];

  // Data-space window at the bottom of memory.
  assign mem_hit    = (mem_addr[ADDR_W-1:AW] == '0);
  assign mem_we_hit = mem_we && mem_hit;
  assign mem_rdata  = mem_hit ? rf_q[mem_addr[AW-1:0]] : '0;

  assign rd_a_data = rf_q[rd_a_addr];
  assign rd_b_data = rf_q[rd_b_addr];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic              wen;
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] q_r;

    gpr_wsel #(
      .DATA_W   (DATA_W),
      .AW       (AW),
      .IDX      (i),
      .PTR_BASE (PTR_BASE)
    ) u_wsel (
      .alu_we    (alu_we),
      .alu_waddr (alu_waddr),
      .alu_wdata (alu_wdata),
      .ptr_upd   (ptr_upd),
      .ptr_sel   (ptr_sel),
      .ptr_nxt   (ptr_nxt),
      .mem_we    (mem_we_hit),
      .mem_waddr (mem_addr[AW-1:0]),
      .mem_wdata (mem_wdata),
      .en        (wen),
      .d         (wd)
    );

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)  q_r <= '0;
      else if (wen)  q_r <= wd;
    end

    assign rf_q[i] = q_r;
  end
endmodule

module gpr_file_chk
  import gpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AW     = 5,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alu_we,
  input logic [AW-1:0]       alu_waddr,
  input logic [DATA_W-1:0]   alu_wdata,
  input logic [AW-1:0]       rd_a_addr,
  input logic [DATA_W-1:0]   rd_a_data,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_we,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W-1:0]   mem_rdata,
  input logic                mem_hit,
  input logic [1:0]          ptr_sel,
  input logic [1:0]          ptr_op,
  input logic [2*DATA_W-1:0] ptr_addr,
  input logic [2*DATA_W-1:0] z_ptr
);
  // R3
  alu_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we |=> (rd_a_addr != $past(alu_waddr)) || (rd_a_data == $past(alu_wdata)));

  // R4
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_hit && !alu_we && (ptr_op == POP_HOLD || ptr_sel == PSEL_NONE))
    |=> (mem_addr != $past(mem_addr)) || (mem_rdata == $past(mem_wdata)));

  // R5
  out_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1:AW] != '0) |-> (!mem_hit && mem_rdata == '0));

  // R8
  z_postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_Z && ptr_op == POP_POSTINC && !alu_we && !mem_we)
    |=> z_ptr == $past(z_ptr) + (2*DATA_W)'(1));

  // R9
  z_predec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_Z && ptr_op == POP_PREDEC) |-> ptr_addr == z_ptr - (2*DATA_W)'(1));

  // R10
  z_hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_Z && ptr_op == POP_HOLD) |-> ptr_addr == z_ptr);

  // R10
  no_sel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == PSEL_NONE) |-> ptr_addr == '0);
endmodule

bind gpr_file gpr_file_chk #(
  .DATA_W (DATA_W),
  .AW     (AW),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .alu_we    (alu_we),
  .alu_waddr (alu_waddr),
  .alu_wdata (alu_wdata),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .mem_hit   (mem_hit),
  .ptr_sel   (ptr_sel),
  .ptr_op    (ptr_op),
  .ptr_addr  (ptr_addr),
  .z_ptr     (z_ptr)
);

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_a_addr, rd_b_addr, alu_waddr;
  logic [7:0]  rd_a_data, rd_b_data, alu_wdata, mem_wdata, mem_rdata;
  logic        alu_we, mem_we, mem_hit;
  logic [15:0] mem_addr, ptr_wdata, ptr_addr, z_ptr;
  logic [1:0]  ptr_sel, ptr_op;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [32];

  gpr_file u_gpr_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .alu_we(alu_we), .alu_waddr(alu_waddr), .alu_wdata(alu_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit),
    .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_wdata(ptr_wdata),
    .ptr_addr(ptr_addr), .z_ptr(z_ptr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic idle();
    alu_we = 1'b0; alu_waddr = '0; alu_wdata = '0;
    mem_we = 1'b0; mem_addr = 16'hFFFF; mem_wdata = '0;
    ptr_sel = 2'd3; ptr_op = 2'd0; ptr_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [15:0] get_ptr(input int s);
    return {mdl[27 + 2*s], mdl[26 + 2*s]};
  endfunction

  task automatic put_ptr(input int s, input logic [15:0] v);
    mdl[26 + 2*s] = v[7:0];
    mdl[27 + 2*s] = v[15:8];
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_addr = 5'(i);
      rd_b_addr = 5'(31 - i);
      #1;
      chk({req, " port A"}, 16'(rd_a_data), 16'(mdl[i]));
      chk({req, " port B"}, 16'(rd_b_data), 16'(mdl[31 - i]));
      tick();
    end
  endtask

  task automatic alu_wr(input int a, input logic [7:0] d);
    alu_we = 1'b1; alu_waddr = 5'(a); alu_wdata = d;
    tick();
    mdl[a] = d;
    idle();
  endtask

  task automatic ptr_do(input int s, input int op, input logic [15:0] v);
    ptr_sel = 2'(s); ptr_op = 2'(op); ptr_wdata = v;
    tick();
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check_all("R1 reset");
  endtask

  task automatic t_alu();
    rd_a_addr = 5'd3;
    alu_we = 1'b1; alu_waddr = 5'd3; alu_wdata = 8'h5A;
    #1 chk("R3 old value same cycle", 16'(rd_a_data), 16'(mdl[3]));
    tick();
    mdl[3] = 8'h5A;
    idle();
    #1 chk("R3 new value next cycle", 16'(rd_a_data), 16'h005A);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 32; i++) alu_wr(i, 8'((i * 7 + 3) ^ 8'hA5));
    check_all("R2 sweep");
  endtask

  task automatic t_mem();
    mem_addr = 16'h000A; mem_we = 1'b1; mem_wdata = 8'h3C;
    #1 chk("R4 hit low window", 16'(mem_hit), 16'h1);
    chk("R4 read before write", 16'(mem_rdata), 16'(mdl[10]));
    tick();
    mdl[10] = 8'h3C;
    mem_we = 1'b0;
    #1 chk("R4 read after write", 16'(mem_rdata), 16'h003C);
    rd_a_addr = 5'd10;
    #1 chk("R4 port A sees mem write", 16'(rd_a_data), 16'h003C);
    mem_addr = 16'h001F;
    #1 chk("R4 top of window", 16'(mem_rdata), 16'(mdl[31]));
    chk("R4 hit top", 16'(mem_hit), 16'h1);
    idle();
  endtask

  task automatic t_mem_oob();
    mem_addr = 16'h0020; mem_we = 1'b1; mem_wdata = 8'hEE;
    #1 chk("R5 miss at 0x20", 16'(mem_hit), 16'h0);
    chk("R5 zero read at 0x20", 16'(mem_rdata), 16'h0);
    tick();
    mem_addr = 16'h8005; mem_we = 1'b1; mem_wdata = 8'hEF;
    #1 chk("R5 miss at 0x8005", 16'(mem_hit), 16'h0);
    tick();
    idle();
    rd_a_addr = 5'd0; rd_b_addr = 5'd5;
    #1 chk("R5 r0 untouched", 16'(rd_a_data), 16'(mdl[0]));
    chk("R5 aliased r5 untouched", 16'(rd_b_data), 16'(mdl[5]));
    check_all("R5 no stray write");
  endtask

  task automatic t_ptr_map();
    alu_wr(26, 8'h11); alu_wr(27, 8'h22); alu_wr(28, 8'h33);
    alu_wr(29, 8'h44); alu_wr(30, 8'h55); alu_wr(31, 8'h66);
    for (int s = 0; s < 3; s++) begin
      ptr_sel = 2'(s); ptr_op = 2'd0;
      #1 chk("R6 pair mapping on hold", ptr_addr, get_ptr(s));
      tick();
    end
    idle();
    #1 chk("R6 z_ptr output", z_ptr, 16'h6655);
  endtask

  task automatic t_ptr_load();
    ptr_do(1, 1, 16'hBEEF);
    put_ptr(1, 16'hBEEF);
    rd_a_addr = 5'd28; rd_b_addr = 5'd29;
    #1 chk("R7 load low byte r28", 16'(rd_a_data), 16'h00EF);
    chk("R7 load high byte r29", 16'(rd_b_data), 16'h00BE);
    check_all("R7 neighbours");
  endtask

  task automatic t_post_inc();
    ptr_do(2, 1, 16'h12FF);
    put_ptr(2, 16'h12FF);
    ptr_sel = 2'd2; ptr_op = 2'd2;
    #1 chk("R8 address is old value", ptr_addr, 16'h12FF);
    tick();
    idle();
    put_ptr(2, 16'h1300);
    #1 chk("R8 carry into high byte", z_ptr, 16'h1300);
    rd_a_addr = 5'd30; rd_b_addr = 5'd31;
    #1 chk("R8 low byte r30", 16'(rd_a_data), 16'h0000);
    chk("R8 high byte r31", 16'(rd_b_data), 16'h0013);
    ptr_do(2, 1, 16'hFFFF);
    put_ptr(2, 16'hFFFF);
    ptr_do(2, 2, 16'h0000);
    put_ptr(2, 16'h0000);
    #1 chk("R8 wrap FFFF to 0000", z_ptr, 16'h0000);
  endtask

  task automatic t_pre_dec();
    ptr_do(0, 1, 16'h0100);
    put_ptr(0, 16'h0100);
    ptr_sel = 2'd0; ptr_op = 2'd3;
    #1 chk("R9 address is decremented", ptr_addr, 16'h00FF);
    tick();
    idle();
    put_ptr(0, 16'h00FF);
    rd_a_addr = 5'd26; rd_b_addr = 5'd27;
    #1 chk("R9 borrow low r26", 16'(rd_a_data), 16'h00FF);
    chk("R9 borrow high r27", 16'(rd_b_data), 16'h0000);
    ptr_do(0, 1, 16'h0000);
    put_ptr(0, 16'h0000);
    ptr_sel = 2'd0; ptr_op = 2'd3;
    #1 chk("R9 wrap address", ptr_addr, 16'hFFFF);
    tick();
    idle();
    put_ptr(0, 16'hFFFF);
    #1 chk("R9 wrap 0000 to FFFF r26", 16'(rd_a_data), 16'h00FF);
    chk("R9 wrap 0000 to FFFF r27", 16'(rd_b_data), 16'h00FF);
  endtask

  task automatic t_hold();
    ptr_sel = 2'd3; ptr_op = 2'd2; ptr_wdata = 16'h5555;
    #1 chk("R10 no-select address zero", ptr_addr, 16'h0000);
    tick();
    ptr_op = 2'd1;
    tick();
    ptr_sel = 2'd1; ptr_op = 2'd0;
    #1 chk("R10 hold shows Y", ptr_addr, get_ptr(1));
    tick();
    idle();
    check_all("R10 nothing changed");
  endtask

  task automatic t_priority();
    alu_we = 1'b1; alu_waddr = 5'd30; alu_wdata = 8'hAA;
    mem_we = 1'b1; mem_addr = 16'h001E; mem_wdata = 8'h55;
    ptr_sel = 2'd2; ptr_op = 2'd1; ptr_wdata = 16'h1234;
    tick();
    idle();
    mdl[30] = 8'hAA; mdl[31] = 8'h12;
    #1 chk("R11 ALU beats pointer and memory", z_ptr, 16'h12AA);
    mem_we = 1'b1; mem_addr = 16'h001C; mem_wdata = 8'h77;
    ptr_sel = 2'd1; ptr_op = 2'd1; ptr_wdata = 16'h4321;
    tick();
    idle();
    put_ptr(1, 16'h4321);
    rd_a_addr = 5'd28;
    #1 chk("R11 pointer beats memory", 16'(rd_a_data), 16'h0021);
    mem_we = 1'b1; mem_addr = 16'h0005; mem_wdata = 8'h5B;
    alu_we = 1'b1; alu_waddr = 5'd6; alu_wdata = 8'h6C;
    tick();
    idle();
    mdl[5] = 8'h5B; mdl[6] = 8'h6C;
    check_all("R11 disjoint writes both land");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rd_a_addr = '0;
    rd_b_addr = '0;
    t_reset();
    t_alu();
    t_sweep();
    t_mem();
    t_mem_oob();
    t_ptr_map();
    t_ptr_load();
    t_post_inc();
    t_pre_dec();
    t_hold();
    t_priority();
    summary();
    $finish;
  end
endmodule